// File: doc/BRIEF.md
# Match-Reset Real-Time Clock Counter

This block is a 32-bit up-counter for keeping real time. It does not step on the system clock. It steps on a slow tick input, nominally 32 kHz. That input passes through a two-flop synchroniser, and each rising edge it detects becomes a single system-clock step pulse. The counter starts from zero and climbs toward a programmable match value. On the tick that finds the count equal to that value, it returns to zero and keeps running. The same tick latches a match status flag.

Software drives the block through a plain register port. The port has a write strobe, a 3-bit word address, write data and a read-data bus that responds combinationally. Counting needs three things at once: a mode select of 1, a run bit and a separate real-time enable bit. The match value and the mode select must be set up while the run bit is clear. While the run bit is set, writes to either are dropped. The status flag stays set until software writes a one to bit 0 of the clear register. The interrupt line is the flag gated by a mask bit.

Top module: `rtc_match_counter`

## Requirements
- R1: After reset, the following all read 0: count, mode select, control, mask and status. The match register reads 0xFFFFFFFF and irqOut is low.
- R2: The counter moves by exactly one for each rising edge of rtcClkIn. The change appears after the third system clock edge that samples rtcClkIn high. Holding rtcClkIn high or low causes no further steps.
- R3: A step happens only when three conditions hold together: the mode select (address 0, bits 2:0) equals 1, control bit 0 (run) is set, and control bit 1 (rtc enable) is set (address 1). If any of them is missing, the count holds. While the run bit is clear, the count reads 0.
- R4: On a step where the count equals the match value (address 2), the count becomes 0 and the status flag (address 4, bit 0) sets. Counting then goes on from 0.
- R5: Writing 1 to bit 0 of the clear register (address 5) clears the status flag. Writing 0 there leaves it unchanged. If a match and a clear fall in the same cycle, the match wins.
- R6: irqOut, and bit 0 of address 7, equal the status flag ANDed with the mask bit (address 3, bit 0).
- R7: While the run bit is set, writes to the match register and to the mode select are ignored.
- R8: Address 6 returns the live count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rtcClkIn | input | 1 | Asynchronous 32 kHz tick input |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| irqOut | output | 1 | Masked match interrupt |

## Verification
A corrupted counter or match register shows up on the count readback after the next tick. A wrong wrap instead shows up at the match tick: either the count runs past the match value, or the status flag fails to rise. A synchroniser or edge detector fault shows within three system cycles of an rtcClkIn edge. The count then either lags, or jumps by more than one for each edge. Flag or mask faults reach irqOut in the cycle after the match, or after the clear write.

// File: rtl/rtc_match_pkg.sv
package rtc_match_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int MODE_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_MODE    = 3'd0,
    ADDR_CTRL    = 3'd1,
    ADDR_MATCH   = 3'd2,
    ADDR_MASK    = 3'd3,
    ADDR_STATUS  = 3'd4,
    ADDR_CLEAR   = 3'd5,
    ADDR_COUNT   = 3'd6,
    ADDR_IRQSTAT = 3'd7
  } regAddr_e;

  localparam logic [MODE_W-1:0] MODE_RTC = 3'd1;

  // strobes from control to datapath
  typedef struct packed {
    logic stepEn;    // advance or wrap this cycle
    logic clrCount;  // hold count at zero
    logic loadMatch; // capture write data into match register
  } dpStrobe_t;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic tickPulse
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= asyncIn;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];

  assign tickPulse = syncQ[SYNC_STAGES-1] & ~prevQ;

  // R2: a detected edge lasts one cycle only
  assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_match_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  tickPulse,
  input  logic                  matchHit,
  output dpStrobe_t             strobes,
  output logic [MODE_W-1:0]     modeSel,
  output logic                  runEn,
  output logic                  rtcEn,
  output logic                  maskBit,
  output logic                  rawFlag,
  output logic                  irqOut
);
  logic wrMode, wrCtrl, wrMatch, wrMask, wrClear;

  always_comb begin
    wrMode  = regWrEn && (regAddr == ADDR_MODE);
    wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
    wrMatch = regWrEn && (regAddr == ADDR_MATCH);
    wrMask  = regWrEn && (regAddr == ADDR_MASK);
    wrClear = regWrEn && (regAddr == ADDR_CLEAR) && regWrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel <= '0;
      runEn   <= 1'b0;
      rtcEn   <= 1'b0;
      maskBit <= 1'b0;
    end else begin
      if (wrMode && !runEn) modeSel <= regWrData[MODE_W-1:0];
      if (wrCtrl) begin
        runEn <= regWrData[0];
        rtcEn <= regWrData[1];
      end
      if (wrMask) maskBit <= regWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rawFlag <= 1'b0;
    else if (matchHit) rawFlag <= 1'b1;
    else if (wrClear)  rawFlag <= 1'b0;
  end

  always_comb begin
    strobes.stepEn    = tickPulse && runEn && rtcEn && (modeSel == MODE_RTC);
    strobes.clrCount  = !runEn;
    strobes.loadMatch = wrMatch && !runEn;
  end

  assign irqOut = rawFlag & maskBit;

  // R5: a match always leaves the flag set, even against a clear
  assert_match_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> rawFlag);
  // R5: a clear without a competing match drops the flag
  assert_clear_drops_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrClear && !matchHit) |=> !rawFlag);
  // R7: mode select frozen during a write attempt while running
  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode && runEn) |=> $stable(modeSel));
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_match_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] matchVal,
  output logic             matchHit
);
  localparam logic [CNT_W-1:0] MATCH_RST = '1;

  logic atMatch;
  assign atMatch  = (countVal == matchVal);
  assign matchHit = strobes.stepEn && atMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  matchVal <= MATCH_RST;
    else if (strobes.loadMatch) matchVal <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                countVal <= '0;
    else if (strobes.clrCount) countVal <= '0;
    else if (strobes.stepEn)  countVal <= atMatch ? '0 : countVal + 1'b1;
  end

  // R4: stepping on the match value returns to zero
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> (countVal == '0));
  // R2: a step below the match climbs by one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepEn && !atMatch && !strobes.clrCount) |=> (countVal == $past(countVal) + 1'b1));
  // R3: no step, no change
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.stepEn && !strobes.clrCount) |=> $stable(countVal));
endmodule

// File: rtl/rtc_match_counter.sv
module rtc_match_counter
  import rtc_match_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rtcClkIn,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]      regWrData,
  output logic [CNT_W-1:0]      regRdData,
  output logic                  irqOut
);
  logic             tickPulse, matchHit;
  dpStrobe_t        strobes;
  logic [MODE_W-1:0] modeSel;
  logic             runEn, rtcEn, maskBit, rawFlag;
  logic [CNT_W-1:0] countVal, matchVal;

  rtc_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(rtcClkIn), .tickPulse(tickPulse));

  rtc_ctrl #(.DATA_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .tickPulse(tickPulse), .matchHit(matchHit),
    .strobes(strobes), .modeSel(modeSel), .runEn(runEn), .rtcEn(rtcEn),
    .maskBit(maskBit), .rawFlag(rawFlag), .irqOut(irqOut));

  rtc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .countVal(countVal), .matchVal(matchVal), .matchHit(matchHit));

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_MODE:    regRdData[MODE_W-1:0] = modeSel;
      ADDR_CTRL:    regRdData[1:0] = {rtcEn, runEn};
      ADDR_MATCH:   regRdData = matchVal;
      ADDR_MASK:    regRdData[0] = maskBit;
      ADDR_STATUS:  regRdData[0] = rawFlag;
      ADDR_COUNT:   regRdData = countVal;
      ADDR_IRQSTAT: regRdData[0] = irqOut;
      default:      regRdData = '0;
    endcase
  end

  // R7: match register frozen against writes while running
  assert_match_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_MATCH && runEn) |=> $stable(matchVal));
  // R3: a disabled run bit leaves the count at zero
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn) |=> (countVal == '0));
endmodule

// File: tb/rtc_match_counter_tb_top.sv
module rtc_match_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rstN = 1'b0, rtcClkIn = 1'b0, regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [W-1:0] regWrData = '0, regRdData;
  logic irqOut;
  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] mCount, mMatch;
  logic [2:0] mMode;
  bit mRun, mRtc, mMask, mFlag;

  rtc_match_counter dut_i (.clk(clk), .rstN(rstN), .rtcClkIn(rtcClkIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit modelActive();
    return mRun && mRtc && (mMode == 3'd1);
  endfunction

  function automatic void modelTick();
    if (modelActive()) begin
      if (mCount == mMatch) begin mCount = '0; mFlag = 1; end
      else mCount = mCount + 1;
    end
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
    case (a)
      3'd0: if (!mRun) mMode = d[2:0];
      3'd1: begin mRun = d[0]; mRtc = d[1]; if (!d[0]) mCount = '0; end
      3'd2: if (!mRun) mMatch = d;
      3'd3: mMask = d[0];
      3'd5: if (d[0]) mFlag = 0;
      default: ;
    endcase
  endtask

  task automatic rdReg(logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic rtcTick();
    @(negedge clk); rtcClkIn = 1;
    repeat (3) @(negedge clk);
    rtcClkIn = 0;
    repeat (3) @(negedge clk);
    modelTick();
  endtask

  task automatic checkAll(string tag);
    logic [W-1:0] v;
    rdReg(3'd6, v); check({tag, " R8 count"}, v, mCount);
    rdReg(3'd4, v); check({tag, " R4 status"}, v, {31'd0, mFlag});
    rdReg(3'd7, v); check({tag, " R6 irqstat"}, v, {31'd0, mFlag & mMask});
    check({tag, " R6 irqOut"}, {31'd0, irqOut}, {31'd0, mFlag & mMask});
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [W-1:0] v, c0;
    void'($urandom(32'd4242));
    mCount = '0; mMatch = '1; mMode = '0; mRun = 0; mRtc = 0; mMask = 0; mFlag = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rdReg(3'd6, v); check("R1 count", v, 0);
    rdReg(3'd2, v); check("R1 match", v, 32'hFFFF_FFFF);
    rdReg(3'd0, v); check("R1 mode", v, 0);
    rdReg(3'd1, v); check("R1 ctrl", v, 0);
    rdReg(3'd4, v); check("R1 status", v, 0);
    check("R1 irqOut", {31'd0, irqOut}, 0);

    // R3 ticks with nothing enabled
    rtcTick(); rtcTick();
    rdReg(3'd6, v); check("R3 idle count", v, 0);

    // R3 run set but rtc enable clear
    wrReg(3'd0, 1); wrReg(3'd2, 5); wrReg(3'd1, 32'h1);
    rtcTick();
    rdReg(3'd6, v); check("R3 rtc bit clear holds", v, 0);

    // R2 exact latency and one step per edge
    wrReg(3'd1, 32'h3);
    rtcTick(); rtcTick();
    rdReg(3'd6, c0); check("R2 two ticks", c0, 2);
    @(negedge clk); rtcClkIn = 1;
    @(negedge clk);
    @(negedge clk); #1 regAddr = 3'd6; #1 check("R2 before third edge", regRdData, c0);
    @(negedge clk); #1 check("R2 after third edge", regRdData, c0 + 1);
    repeat (10) @(negedge clk);
    #1 check("R2 held high no extra step", regRdData, c0 + 1);
    rtcClkIn = 0; repeat (3) @(negedge clk);
    modelTick();

    // R7 writes ignored while running
    wrReg(3'd2, 32'd100); rdReg(3'd2, v); check("R7 match locked", v, 5);
    wrReg(3'd0, 3'd4);    rdReg(3'd0, v); check("R7 mode locked", v, 1);

    // R4 wrap and flag, R6 mask
    wrReg(3'd3, 1);
    for (int i = 0; i < 4; i++) rtcTick();
    checkAll("wrap");
    rtcTick(); checkAll("post-wrap");
    // R5 write 0 no effect, write 1 clears
    wrReg(3'd5, 0); rdReg(3'd4, v); check("R5 clear zero ignored", v, 1);
    wrReg(3'd5, 1); rdReg(3'd4, v); check("R5 clear one", v, 0);
    check("R6 irq after clear", {31'd0, irqOut}, 0);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      logic [2:0] md;
      int n;
      wrReg(3'd1, 0);
      md = ($urandom_range(0, 1) == 0) ? 3'd1 : 3'($urandom_range(0, 7));
      wrReg(3'd0, {29'd0, md});
      wrReg(3'd2, $urandom_range(0, 12));
      wrReg(3'd5, 1);
      wrReg(3'd3, $urandom_range(0, 1));
      wrReg(3'd1, {30'd0, ($urandom_range(0, 3) != 0), 1'b1});
      n = $urandom_range(0, 30);
      for (int t = 0; t < n; t++) rtcTick();
      checkAll("rand R3");
    end

    done = 1;
    finishRun();
  end
endmodule